// File: doc/BRIEF.md
# LCD Driver Command Decoder

This block sits behind an I2C slave front end inside a segment LCD driver. The front end has already deframed the serial traffic into whole bytes. It tags each byte as either a command byte or a display data byte, and it reports bus START (including a repeated START) and STOP events. The decoder turns command bytes into configuration state: the display mode fields, a display RAM data pointer and a device-select value. It writes display data bytes into an external display RAM through a simple write port, and it tells the front end whether to acknowledge each byte.

Command bytes are acknowledged by every device that the bus address reaches, whatever its hardware subaddress. A display data byte is acknowledged and stored only when the device's two subaddress pins equal the stored device-select value. Each stored byte goes to the address held in the pointer, and the pointer then moves on by one, wrapping at the end of the RAM. Bytes are acted on only between a START and the following STOP. A repeated START keeps the transfer open, and the pointer keeps its value.

Opcode map (upper bits of a command byte): `1100_EBMM` mode set, `0000_hhhh` pointer high nibble, `0001_llll` pointer low nibble, `1110_00dd` device select. Any other value is an undefined opcode.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, disp_en, clk_out_en and bias_sel are 0, drive_mode is 00, bp_count is 4, dev_sel is 00, ack_valid and ram_we are 0, and the first stored display byte goes to address 0.
- R2: A mode-set command `1100_EBMM` sets disp_en to E (bit 3), bias_sel to B (bit 2) and drive_mode to MM (bits 1:0), visible the cycle after the byte.
- R3: bp_count reports the number of backplanes for drive_mode: 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4.
- R4: clk_out_en (internal clock driven to the clock pin) always equals disp_en, so it is 0 while the display is blanked.
- R5: Each command byte received in an open transfer gives ack_valid=1 and ack=1 the next cycle, for any hw_subaddr.
- R6: A display data byte in an open transfer with hw_subaddr equal to dev_sel gives ack_valid=1 and ack=1 the next cycle, together with ram_we=1, ram_addr equal to the pointer and ram_wdata equal to the byte.
- R7: Command `0000_hhhh` replaces pointer bits 7:4 with hhhh, and `0001_llll` replaces pointer bits 3:0 with llll. The other bits are kept.
- R8: After each stored display byte, the pointer goes up by one. From RAM_DEPTH-1 or any higher loaded value it goes to 0.
- R9: A display data byte whose hw_subaddr differs from dev_sel gives ack_valid=1 and ack=0 and no RAM write, and it leaves the pointer unchanged.
- R10: Command `1110_00dd` sets dev_sel to dd.
- R11: A command byte matching none of the four opcodes is acknowledged (R5) but changes no mode field, pointer or dev_sel.
- R12: Bytes after a STOP and before the next START give no ack_valid and no write, and they change no state. A START during an open transfer keeps it open, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A deframed byte is present this cycle |
| in_byte | input | 8 | The byte |
| in_is_cmd | input | 1 | 1: command byte, 0: display data byte |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| hw_subaddr | input | 2 | Level on the two hardware subaddress pins |
| ack_valid | output | 1 | Acknowledge decision for the previous byte is valid |
| ack | output | 1 | 1: acknowledge, 0: leave the line released |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | $clog2(RAM_DEPTH) | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| disp_en | output | 1 | Display enabled (0: blanked) |
| clk_out_en | output | 1 | Drive internal clock onto the clock pin |
| bias_sel | output | 1 | LCD bias configuration bit |
| drive_mode | output | 2 | Drive mode field as written |
| bp_count | output | 3 | Number of active backplanes, 1 to 4 |
| dev_sel | output | 2 | Stored device-select value |

## Verification
The assertions take as given that the front end never raises in_valid in the same cycle as bus_start or bus_stop, and never raises bus_start and bus_stop together. A byte is therefore always judged against a transfer state that has settled. The bench drives each byte, START and STOP in a cycle of its own, with in_valid low in between, so every one-cycle ack and write pulse can be tied to exactly one byte. hw_subaddr is changed only while in_valid is low.

// File: rtl/lcdc_pkg.sv
// Shared types for the LCD command decoder.
// Assumes: byte-wide commands; opcode map fixed as listed in the brief.
package lcdc_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MODE   = 3'd1,
        OP_PTR_HI = 3'd2,
        OP_PTR_LO = 3'd3,
        OP_DEVSEL = 3'd4
    } lcdc_op_e;

    typedef struct packed {
        logic       en;
        logic       bias;
        logic [1:0] mux;
    } lcdc_mode_t;

    localparam lcdc_mode_t MODE_RESET = '{en: 1'b0, bias: 1'b0, mux: 2'b00};

    // Backplane count for a drive mode field (00 means four backplanes).
    function automatic logic [2:0] bp_of(input logic [1:0] mux);
        case (mux)
            2'b01:   bp_of = 3'd1;
            2'b10:   bp_of = 3'd2;
            2'b11:   bp_of = 3'd3;
            default: bp_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_classify.sv
// Combinational opcode classifier for one command byte.
// Splits the byte into an opcode and its argument fields. Assumes: the
// caller qualifies the result with a valid command strobe.
module lcdc_classify
    import lcdc_pkg::*;
(
    input  logic [7:0]  cmd_byte,
    output lcdc_op_e    op,
    output lcdc_mode_t  mode_arg,
    output logic [3:0]  nib_arg,
    output logic [1:0]  dev_arg
);

    // Opcode lookup from the upper bits.
    always_comb begin
        op = OP_NONE;
        case (cmd_byte[7:4])
            4'b1100: op = OP_MODE;
            4'b0000: op = OP_PTR_HI;
            4'b0001: op = OP_PTR_LO;
            4'b1110: op = (cmd_byte[3:2] == 2'b00) ? OP_DEVSEL : OP_NONE;
            default: op = OP_NONE;
        endcase
    end

    // Argument fields, meaningful only for the matching opcode.
    always_comb begin
        mode_arg.en   = cmd_byte[3];
        mode_arg.bias = cmd_byte[2];
        mode_arg.mux  = cmd_byte[1:0];
        nib_arg       = cmd_byte[3:0];
        dev_arg       = cmd_byte[1:0];
    end

endmodule

// File: rtl/lcdc_ptr.sv
// Display RAM data pointer.
// Loads a high or low nibble and steps by one after each stored byte. At
// RAM_DEPTH-1 or above it wraps to zero. Assumes: 16 < RAM_DEPTH <= 256 and
// at most one of load/step per cycle.
module lcdc_ptr #(
    parameter int RAM_DEPTH = 160,
    parameter int PTR_W     = $clog2(RAM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_hi,
    input  logic             ld_lo,
    input  logic [3:0]       nib,
    input  logic             step,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

    logic [7:0]       ext;
    logic [7:0]       hi_val;
    logic [7:0]       lo_val;
    logic [PTR_W-1:0] next_step;

    // Byte-wide view of the pointer for nibble replacement.
    always_comb begin
        ext       = 8'(ptr_q);
        hi_val    = {nib, ext[3:0]};
        lo_val    = {ext[7:4], nib};
        next_step = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
    end

    // Pointer register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_hi) begin
            ptr_q <= hi_val[PTR_W-1:0];
        end else if (ld_lo) begin
            ptr_q <= lo_val[PTR_W-1:0];
        end else if (step) begin
            ptr_q <= next_step;
        end
    end

endmodule

// File: rtl/lcdc_cfg.sv
// Configuration registers: mode fields and device-select value.
// Assumes: write strobes are already qualified by a valid command.
module lcdc_cfg
    import lcdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mode,
    input  lcdc_mode_t mode_arg,
    input  logic       wr_dev,
    input  logic [1:0] dev_arg,
    output lcdc_mode_t mode_q,
    output logic [1:0] dev_q
);

    // Mode register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (wr_mode) begin
            mode_q <= mode_arg;
        end
    end

    // Device-select register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q <= 2'b00;
        end else if (wr_dev) begin
            dev_q <= dev_arg;
        end
    end

endmodule

// File: rtl/lcd_cmd_decoder.sv
// LCD driver command decoder top.
// Tracks the open bus transfer, decodes command bytes, stores matching
// display bytes through the RAM write port and produces the acknowledge
// decision one cycle after each byte. Assumes: in_valid never coincides
// with bus_start or bus_stop.
module lcd_cmd_decoder
    import lcdc_pkg::*;
#(
    parameter int RAM_DEPTH = 160,
    localparam int PTR_W    = $clog2(RAM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_is_cmd,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic [1:0]       hw_subaddr,
    output logic             ack_valid,
    output logic             ack,
    output logic             ram_we,
    output logic [PTR_W-1:0] ram_addr,
    output logic [7:0]       ram_wdata,
    output logic             disp_en,
    output logic             clk_out_en,
    output logic             bias_sel,
    output logic [1:0]       drive_mode,
    output logic [2:0]       bp_count,
    output logic [1:0]       dev_sel
);

    logic             sess_active;
    logic             cmd_ok;
    logic             dat_seen;
    logic             dat_hit;
    lcdc_op_e         op;
    lcdc_mode_t       mode_arg;
    lcdc_mode_t       mode_q;
    logic [3:0]       nib_arg;
    logic [1:0]       dev_arg;
    logic [PTR_W-1:0] ptr_q;

    // Transfer window: opened by START, closed by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_active <= 1'b0;
        end else if (bus_start) begin
            sess_active <= 1'b1;
        end else if (bus_stop) begin
            sess_active <= 1'b0;
        end
    end

    // Byte qualification against transfer window and subaddress.
    always_comb begin
        cmd_ok   = in_valid && in_is_cmd && sess_active;
        dat_seen = in_valid && !in_is_cmd && sess_active;
        dat_hit  = dat_seen && (hw_subaddr == dev_sel);
    end

    lcdc_classify u_classify (
        .cmd_byte (in_byte),
        .op       (op),
        .mode_arg (mode_arg),
        .nib_arg  (nib_arg),
        .dev_arg  (dev_arg)
    );

    lcdc_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (cmd_ok && (op == OP_MODE)),
        .mode_arg (mode_arg),
        .wr_dev   (cmd_ok && (op == OP_DEVSEL)),
        .dev_arg  (dev_arg),
        .mode_q   (mode_q),
        .dev_q    (dev_sel)
    );

    lcdc_ptr #(
        .RAM_DEPTH (RAM_DEPTH),
        .PTR_W     (PTR_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (cmd_ok && (op == OP_PTR_HI)),
        .ld_lo (cmd_ok && (op == OP_PTR_LO)),
        .nib   (nib_arg),
        .step  (dat_hit),
        .ptr_q (ptr_q)
    );

    // Acknowledge decision, registered one cycle after the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= cmd_ok || dat_seen;
            ack       <= cmd_ok || dat_hit;
        end
    end

    // Display RAM write port, registered with the pointer value used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= dat_hit;
            if (dat_hit) begin
                ram_addr  <= ptr_q;
                ram_wdata <= in_byte;
            end
        end
    end

    // Mode fields out; the clock pin follows the display enable.
    always_comb begin
        disp_en    = mode_q.en;
        clk_out_en = mode_q.en;
        bias_sel   = mode_q.bias;
        drive_mode = mode_q.mux;
        bp_count   = bp_of(mode_q.mux);
    end

endmodule

// File: rtl/lcdc_checker.sv
// Assertion checker for lcd_cmd_decoder, attached with bind.
// Assumes the input discipline stated in the brief.
module lcdc_checker #(
    parameter int RAM_DEPTH = 160,
    parameter int PTR_W     = $clog2(RAM_DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_is_cmd,
    input logic [7:0]       in_byte,
    input logic [1:0]       hw_subaddr,
    input logic             sess_active,
    input logic [1:0]       dev_sel,
    input logic [PTR_W-1:0] ptr_q,
    input logic             ack_valid,
    input logic             ack,
    input logic             ram_we,
    input logic             disp_en,
    input logic             bias_sel,
    input logic [1:0]       drive_mode,
    input logic [2:0]       bp_count
);

    logic undef_op;
    assign undef_op = !(in_byte[7:4] inside {4'b0000, 4'b0001, 4'b1100})
                      && (in_byte[7:2] != 6'b111000);

    p_mode_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_cmd && sess_active && in_byte[7:4] == 4'b1100
        |=> {disp_en, bias_sel, drive_mode} == $past(in_byte[3:0]));

    p_four_bp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_mode == 2'b00 |-> bp_count == 3'd4);

    p_cmd_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_cmd && sess_active |=> ack_valid && ack);

    p_data_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_cmd && sess_active && hw_subaddr == dev_sel
        |=> ram_we && ack);

    p_write_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ack_valid && ack);

    p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_cmd && sess_active && hw_subaddr == dev_sel
        && ptr_q == PTR_W'(RAM_DEPTH - 1) |=> ptr_q == '0);

    p_data_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_cmd && sess_active && hw_subaddr != dev_sel
        |=> ack_valid && !ack && !ram_we && $stable(ptr_q));

    p_undef_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_cmd && sess_active && undef_op
        |=> $stable(ptr_q) && $stable(dev_sel) && $stable(disp_en)
            && $stable(bias_sel) && $stable(drive_mode));

    p_idle_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !sess_active |=> !ack_valid && !ram_we && $stable(ptr_q));

endmodule

bind lcd_cmd_decoder lcdc_checker #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_is_cmd   (in_is_cmd),
    .in_byte     (in_byte),
    .hw_subaddr  (hw_subaddr),
    .sess_active (sess_active),
    .dev_sel     (dev_sel),
    .ptr_q       (ptr_q),
    .ack_valid   (ack_valid),
    .ack         (ack),
    .ram_we      (ram_we),
    .disp_en     (disp_en),
    .bias_sel    (bias_sel),
    .drive_mode  (drive_mode),
    .bp_count    (bp_count)
);

// File: tb/lcd_cmd_decoder_tb.sv
// Self-checking bench: sweeps every command byte, every subaddress pairing,
// pointer wrap cases and transfer window handling against a bench model.
module lcd_cmd_decoder_tb;

    localparam int DEPTH = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_cmd = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic [1:0] hw_subaddr = 2'b00;
    logic       ack_valid, ack, ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       disp_en, clk_out_en, bias_sel;
    logic [1:0] drive_mode, dev_sel;
    logic [2:0] bp_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    int m_en = 0, m_b = 0, m_m = 0, m_dev = 0, m_ptr = 0;

    always #4 clk = ~clk;

    lcd_cmd_decoder #(.RAM_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_is_cmd(in_is_cmd), .bus_start(bus_start), .bus_stop(bus_stop),
        .hw_subaddr(hw_subaddr), .ack_valid(ack_valid), .ack(ack),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .disp_en(disp_en), .clk_out_en(clk_out_en), .bias_sel(bias_sel),
        .drive_mode(drive_mode), .bp_count(bp_count), .dev_sel(dev_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One byte in one cycle; outputs sampled at the following falling edge.
    task automatic send(input logic [7:0] b, input logic cmd);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_is_cmd = cmd;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic check_cfg(input string tag);
        chk({tag, " R2 disp_en"}, disp_en, m_en);
        chk({tag, " R2 bias_sel"}, bias_sel, m_b);
        chk({tag, " R2 drive_mode"}, drive_mode, m_m);
        chk({tag, " R3 bp_count"}, bp_count, (m_m == 0) ? 4 : m_m);
        chk({tag, " R4 clk_out_en"}, clk_out_en, m_en);
        chk({tag, " R10 dev_sel"}, dev_sel, m_dev);
    endtask

    // Model of a command byte's effect.
    task automatic model_cmd(input int b);
        int hi = b / 16;
        if (hi == 12) begin
            m_en = (b / 8) % 2; m_b = (b / 4) % 2; m_m = b % 4;
        end else if (hi == 0) begin
            m_ptr = (b % 16) * 16 + (m_ptr % 16);
        end else if (hi == 1) begin
            m_ptr = (m_ptr / 16) * 16 + (b % 16);
        end else if (b / 4 == 56) begin
            m_dev = b % 4;
        end
    endtask

    task automatic cmd(input int b, input string tag);
        send(8'(b), 1'b1);
        model_cmd(b);
        chk({tag, " R5 ack_valid"}, ack_valid, 1);
        chk({tag, " R5 ack"}, ack, 1);
        check_cfg(tag);
    endtask

    // Data byte with the model deciding whether it must be stored.
    task automatic data(input int b, input string tag);
        bit hit = (int'(hw_subaddr) == m_dev);
        send(8'(b), 1'b0);
        chk({tag, " R6/R9 ack_valid"}, ack_valid, 1);
        chk({tag, " R6/R9 ack"}, ack, hit);
        chk({tag, " R6/R9 ram_we"}, ram_we, hit);
        if (hit) begin
            chk({tag, " R6 R7 R8 ram_addr"}, ram_addr, m_ptr);
            chk({tag, " R6 ram_wdata"}, ram_wdata, b);
            m_ptr = (m_ptr >= DEPTH - 1) ? 0 : m_ptr + 1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 ack_valid", ack_valid, 0);
        chk("R1 ram_we", ram_we, 0);
        chk("R1 bp_count", bp_count, 4);
        check_cfg("R1");
        rst_n = 1'b1;
        pulse_start();
        hw_subaddr = 2'b00;
        data(8'h5A, "R1 first write");

        // Every command byte, each followed by a matching data byte.
        for (int b = 0; b < 256; b++) begin
            hw_subaddr = 2'(m_dev);
            cmd(b, "sweep R7 R10 R11");
            hw_subaddr = 2'(m_dev);
            data(b ^ 8'hA5, "sweep R11 ptr");
        end

        // Device select against every subaddress.
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 4; s++) begin
                hw_subaddr = 2'(s);
                cmd(8'hE0 + d, "R10 devsel");
                data(16 * d + s, "R6 R9 subaddr");
            end
        end

        // Wrap from the last address and from a loaded value above it.
        hw_subaddr = 2'(m_dev);
        cmd(8'h09, "R7 hi"); cmd(8'h1F, "R7 lo");
        data(8'h11, "R8 last"); data(8'h22, "R8 wrap");
        cmd(8'h0F, "R7 hi"); cmd(8'h1F, "R7 lo");
        data(8'h33, "R8 above"); data(8'h44, "R8 wrap2");

        // Closed transfer: nothing acknowledged, stored or changed.
        cmd(8'hC0, "R2 base");
        pulse_stop();
        send(8'hCB, 1'b1);
        chk("R12 idle cmd ack_valid", ack_valid, 0);
        check_cfg("R12 idle cmd");
        send(8'h02, 1'b1);
        send(8'h77, 1'b0);
        chk("R12 idle data ack_valid", ack_valid, 0);
        chk("R12 idle data ram_we", ram_we, 0);
        pulse_start();
        data(8'h88, "R12 ptr kept");
        pulse_start();
        data(8'h99, "R12 restart");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule